// File: doc/BRIEF.md
# Worst-case-paced shared bus arbiter

This block decides which of N cores may use a single shared bus towards a banked second-level cache. Each core is marked by configuration as hard real-time or best-effort. A core raises its request line, receives a one-hot grant that lasts for the configured bus latency, and sees a one-cycle done pulse in the final grant cycle. Hard real-time requests always beat best-effort requests. Each class has its own round-robin order.

The block computes an interference bound from the configuration: the number of hard real-time cores times the larger of the bus and bank latencies, minus one, with a floor of zero. A policy input selects one of three modes. In the eager mode a hard real-time core is served as soon as the bus is free. In the paced mode a saturating down-counter is loaded with the bound whenever a hard real-time access finishes. While that counter is nonzero, every hard real-time request is held back, and best-effort requests pass freely. In the timing-analysis mode every request must first have waited the bound number of cycles. A core running alone therefore sees the worst-case interference.

Top module: `wcpace_arb`

## Requirements
- R1: At most one grant bit is high at any time. A granted core keeps its grant for max(lat_bus,1) consecutive cycles. `done` pulses for that core only in the last of those cycles.
- R2: Arbitration happens only while no grant is active. After a done pulse in cycle d, a request still pending is granted at the earliest in cycle d+2.
- R3: When the bus is free and any eligible hard real-time request is present, the grant goes to a hard real-time core.
- R4: Eligible hard real-time cores are served in round-robin order. The search starts at the core after the last hard real-time winner, or at core 0 after reset.
- R5: Best-effort cores are served in round-robin order by a pointer of their own, which hard real-time grants do not move.
- R6: The bound B equals popcount(rt_flag) * max(lat_bus, lat_bank) - 1, and is 0 when that product is 0.
- R7: With policy 1 (paced), a hard real-time request pending when a hard real-time done pulse occurs in cycle d is granted in cycle d+2+B.
- R8: With policy 1, a best-effort request is granted without regard to the pacing counter. After a hard real-time done in cycle d, a pending best-effort request is granted in cycle d+2.
- R9: With policy 0 or 3 (eager), a hard real-time request pending at a done in cycle d is granted in cycle d+2. A request raised with the bus idle is granted in the next cycle.
- R10: With policy 2 (analysis), a request raised in cycle c on an idle bus with no competitor is granted in cycle c+1+B.
- R11: B is recomputed only in cycles with no grant active. A latency change made during a grant does not alter the pacing loaded at the end of that grant.
- R12: After reset no grant and no done are active, both round-robin pointers point to core 0, and the pacing counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N | Per-core request, held until the core's done |
| rt_flag | input | N | 1 marks a core as hard real-time |
| policy | input | 2 | 0/3 eager, 1 paced, 2 timing analysis |
| lat_bus | input | LAT_W | Bus latency in cycles (0 acts as 1) |
| lat_bank | input | LAT_W | Bank latency in cycles |
| grant | output | N | One-hot bus grant |
| done | output | N | Last-cycle pulse of the current grant |

## Verification
A lone hard real-time core issues continuous requests across a sweep of real-time core counts and both latencies. The measured gap between a done pulse and the next grant separates the bound arithmetic (including the zero-floor case) from the eager and paced behaviour. A mixed request from one hard real-time and one best-effort core in paced mode shows the bypass and the later paced grant. Simultaneous requests from several cores of one class expose the round-robin order. A specific sequence of grants shows that the two pointers are separate. Single requests in analysis mode across a bound sweep check the exact added delay. A latency change made during a grant checks when the bound is resampled.

// File: rtl/wcpace_pkg.sv
package wcpace_pkg;

   typedef enum logic [1:0] {
      POL_EAGER  = 2'd0,
      POL_PACED  = 2'd1,
      POL_PROBE  = 2'd2,
      POL_EAGER2 = 2'd3
   } pol_e;

endpackage

// File: rtl/wcpace_bound.sv
// Interference bound: count(rt) * max(bus, bank) - 1, floored at zero.
// Resampled only when the update enable is high.
module wcpace_bound #(
   parameter int N     = 4,
   parameter int LAT_W = 4,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic [N-1:0]     rt_flag,
   input  logic [LAT_W-1:0] lat_bus,
   input  logic [LAT_W-1:0] lat_bank,
   output logic [CNT_W-1:0] bound_q
);
   logic [CNT_W-1:0] bound_d;

   always_comb begin
      int n_rt;
      int lmax;
      int prod;
      n_rt = 0;
      for (int i = 0; i < N; i++) n_rt += int'(rt_flag[i]);
      lmax = (lat_bus > lat_bank) ? int'(lat_bus) : int'(lat_bank);
      prod = n_rt * lmax;
      bound_d = (prod == 0) ? '0 : CNT_W'(prod - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bound_q <= '0;
      else if (upd) bound_q <= bound_d;
   end
endmodule

// File: rtl/wcpace_rr.sv
// Round-robin picker: first eligible index at or after the pointer.
module wcpace_rr #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     elig,
   input  logic [IDX_W-1:0] ptr,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int k = 0; k < N; k++) begin
         int j;
         j = (int'(ptr) + k) % N;
         if (!hit && elig[j]) begin
            hit = 1'b1;
            idx = IDX_W'(j);
         end
      end
   end
endmodule

// File: rtl/wcpace_age.sv
// Per-core waiting-time counters for the timing-analysis mode.
module wcpace_age #(
   parameter int N     = 4,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   input  logic [N-1:0]     grant,
   input  logic [CNT_W-1:0] bound,
   output logic [N-1:0]     ripe
);
   for (genvar i = 0; i < N; i++) begin : g_core
      logic [CNT_W-1:0] age_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  age_q <= '0;
         else if (!req[i] || grant[i]) age_q <= '0;
         else if (age_q < bound)      age_q <= age_q + 1'b1;
      end
      assign ripe[i] = (age_q >= bound);
   end
endmodule

// File: rtl/wcpace_arb.sv
module wcpace_arb
   import wcpace_pkg::*;
#(
   parameter int N        = 4,
   parameter int LAT_W    = 4,
   parameter bit EN_PROBE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   input  logic [N-1:0]     rt_flag,
   input  logic [1:0]       policy,
   input  logic [LAT_W-1:0] lat_bus,
   input  logic [LAT_W-1:0] lat_bank,
   output logic [N-1:0]     grant,
   output logic [N-1:0]     done
);
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
   localparam int CNT_W = $clog2(N * ((1 << LAT_W) - 1) + 1);

   if (N < 2) begin : g_bad_n
      $error("wcpace_arb: N must be at least 2");
   end
   if (LAT_W < 1 || LAT_W > 8) begin : g_bad_lat
      $error("wcpace_arb: LAT_W out of range 1..8");
   end

   pol_e             pol;
   logic             paced, probe, busy, last, issue;
   logic [LAT_W-1:0] cnt_q;
   logic [N-1:0]     grant_q;
   logic             gnt_rt_q;
   logic [CNT_W-1:0] pace_q, bound_q;
   logic [N-1:0]     ripe, ripe_m;
   logic [N-1:0]     elig  [2];
   logic [IDX_W-1:0] ptr_q [2];
   logic [IDX_W-1:0] pick  [2];
   logic             hit   [2];
   logic             win_cls;
   logic [IDX_W-1:0] win_idx;

   assign pol   = pol_e'(policy);
   assign paced = (pol == POL_PACED);
   assign busy  = |grant_q;
   assign last  = busy && (cnt_q == LAT_W'(1));
   assign grant = grant_q;
   assign done  = last ? grant_q : '0;

   wcpace_bound #(.N(N), .LAT_W(LAT_W), .CNT_W(CNT_W)) u_bound (
      .clk(clk), .rst_n(rst_n), .upd(!busy), .rt_flag(rt_flag),
      .lat_bus(lat_bus), .lat_bank(lat_bank), .bound_q(bound_q)
   );

   if (EN_PROBE) begin : g_probe
      wcpace_age #(.N(N), .CNT_W(CNT_W)) u_age (
         .clk(clk), .rst_n(rst_n), .req(req), .grant(grant_q),
         .bound(bound_q), .ripe(ripe)
      );
      assign probe = (pol == POL_PROBE);
   end else begin : g_no_probe
      assign ripe  = '1;
      assign probe = 1'b0;
   end

   assign ripe_m  = probe ? ripe : '1;
   assign elig[0] = req & rt_flag & ripe_m & {N{!(paced && (pace_q != '0))}};
   assign elig[1] = req & ~rt_flag & ripe_m;

   for (genvar c = 0; c < 2; c++) begin : g_cls
      wcpace_rr #(.N(N), .IDX_W(IDX_W)) u_rr (
         .elig(elig[c]), .ptr(ptr_q[c]), .hit(hit[c]), .idx(pick[c])
      );
   end

   assign win_cls = !hit[0];
   assign win_idx = hit[0] ? pick[0] : pick[1];
   assign issue   = !busy && (hit[0] || hit[1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q  <= '0;
         cnt_q    <= '0;
         gnt_rt_q <= 1'b0;
         ptr_q[0] <= '0;
         ptr_q[1] <= '0;
      end else if (issue) begin
         grant_q  <= {{(N-1){1'b0}}, 1'b1} << win_idx;
         cnt_q    <= (lat_bus == '0) ? LAT_W'(1) : lat_bus;
         gnt_rt_q <= !win_cls;
         ptr_q[win_cls] <= (win_idx == IDX_W'(N - 1)) ? '0 : win_idx + 1'b1;
      end else if (last) begin
         grant_q <= '0;
      end else if (busy) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        pace_q <= '0;
      else if (last && gnt_rt_q && paced) pace_q <= bound_q;
      else if (pace_q != '0)             pace_q <= pace_q - 1'b1;
   end
endmodule

// File: rtl/wcpace_arb_chk.sv
module wcpace_arb_chk
   import wcpace_pkg::*;
#(
   parameter int N     = 4,
   parameter int CNT_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N-1:0]     req,
   input logic [N-1:0]     rt_flag,
   input logic [1:0]       policy,
   input logic [N-1:0]     grant,
   input logic [N-1:0]     done,
   input logic [CNT_W-1:0] bound
);
   logic [CNT_W:0]   gap_q;
   logic [CNT_W-1:0] held_b_q;
   logic             eager, paced;

   assign eager = (policy == POL_EAGER) || (policy == POL_EAGER2);
   assign paced = (policy == POL_PACED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q    <= '1;
         held_b_q <= '0;
      end else if (paced && |(done & rt_flag)) begin
         gap_q    <= '0;
         held_b_q <= bound;
      end else if (gap_q != '1) begin
         gap_q <= gap_q + 1'b1;
      end
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R1
   AST_DONE_IN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (done & ~grant) == '0); // R1
   AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant && !(|done)) |=> grant == $past(grant)); // R1
   AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      |done |=> grant == '0); // R2
   AST_RT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (grant == '0 && eager && |(req & rt_flag)) |=> (grant & ~rt_flag) == '0); // R3
   AST_PACE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (paced && |(grant & rt_flag) && $past(grant) == '0) |-> gap_q > {1'b0, held_b_q}); // R7
endmodule

bind wcpace_arb wcpace_arb_chk #(.N(N), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .rt_flag(rt_flag), .policy(policy),
   .grant(grant), .done(done), .bound(bound_q)
);

// File: tb/sim_wcpace_arb.sv
module sim_wcpace_arb;
   localparam int N = 4;
   localparam int LW = 4;
   localparam int WD = 150000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0, rt_flag = '0, grant, done;
   logic [1:0]    policy = 2'd0;
   logic [LW-1:0] lat_bus = 4'd1, lat_bank = 4'd0;
   int cyc = 0, n_chk = 0, n_err = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wcpace_arb #(.N(N), .LAT_W(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .rt_flag(rt_flag), .policy(policy),
      .lat_bus(lat_bus), .lat_bank(lat_bank), .grant(grant), .done(done)
   );

   always @(posedge clk) if (cyc == WD) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int bnd(input int n, input int lb, input int lk);
      int p;
      p = n * ((lb > lk) ? lb : lk);
      return (p == 0) ? 0 : p - 1;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; req = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic setcfg(input logic [N-1:0] rt, input int pol, input int lb, input int lk);
      do_reset();
      rt_flag = rt; policy = 2'(pol); lat_bus = LW'(lb); lat_bank = LW'(lk);
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_grant(output int who, output int at);
      int k;
      k = 0; who = -1; at = -1;
      do begin @(negedge clk); k++; end while (grant == '0 && k < 400);
      if (grant != '0) begin
         for (int i = 0; i < N; i++) if (grant[i]) who = i;
         at = cyc;
      end
   endtask

   task automatic finish_grant(input int who, output int len, output int dat);
      int k;
      len = 1; k = 0;
      while (!(who >= 0 && done[who]) && k < 100) begin
         @(negedge clk); len++; k++;
      end
      dat = cyc;
   endtask

   initial begin
      int w, at, len, d, c, b;
      do_reset();
      // R12: reset state
      chk("R12 grant after reset", int'(grant), 0);
      chk("R12 done after reset", int'(done), 0);

      // R1: grant length sweep over cores and bus latency (0 acts as 1)
      for (int l = 0; l < 6; l++) begin
         for (int k = 0; k < N; k++) begin
            setcfg(4'b0000, 0, l, 0);
            c = cyc; req[k] = 1'b1;
            wait_grant(w, at);
            chk("R1 grant owner", w, k);
            chk("R9 idle grant delay", at - c, 1);
            finish_grant(w, len, d);
            req[k] = 1'b0;
            chk("R1 grant length", len, (l == 0) ? 1 : l);
            @(negedge clk);
            chk("R2 bus idle after done", int'(grant), 0);
         end
      end

      // R12: pacing counter zero after reset -> immediate paced grant
      setcfg(4'b0001, 1, 3, 5);
      c = cyc; req[0] = 1'b1;
      wait_grant(w, at);
      chk("R12 paced first grant delay", at - c, 1);

      // R6 R7 R9: continuous hard real-time stream, sweep bound inputs
      for (int pol = 0; pol < 4; pol++) begin
         if (pol == 2) continue;
         for (int n = 1; n <= N; n++) begin
            for (int lb = 1; lb <= 3; lb += 2) begin
               for (int lk = 0; lk <= 5; lk++) begin
                  if (lk == 1 || lk == 3 || lk == 4) continue;
                  setcfg(4'((1 << n) - 1), pol, lb, lk);
                  b = bnd(n, lb, lk);
                  req[0] = 1'b1;
                  wait_grant(w, at);
                  finish_grant(w, len, d);
                  wait_grant(w, at);
                  if (pol == 1) chk("R7 R6 paced gap", at - d, 2 + b);
                  else          chk("R9 eager gap", at - d, 2);
                  req[0] = 1'b0;
               end
            end
         end
      end

      // R3 R8: hard real-time core 0 and best-effort core 2, paced, B=7
      setcfg(4'b0001, 1, 2, 8);
      c = cyc; req = 4'b0101;
      wait_grant(w, at);
      chk("R3 real-time wins", w, 0);
      finish_grant(w, len, d);
      wait_grant(w, at);
      chk("R8 best-effort bypass owner", w, 2);
      chk("R8 best-effort bypass gap", at - d, 2);
      finish_grant(w, len, c);
      req[2] = 1'b0;
      wait_grant(w, at);
      chk("R7 paced owner", w, 0);
      chk("R7 paced gap with bypass", at - d, 2 + 7);
      req = '0;

      // R3: eager mode, simultaneous requests
      setcfg(4'b0100, 0, 1, 0);
      req = 4'b1111;
      wait_grant(w, at);
      chk("R3 real-time wins eager", w, 2);
      req = '0;

      // R4: round robin among hard real-time cores 0,1,3
      setcfg(4'b1011, 0, 1, 1);
      req = 4'b1011;
      for (int s = 0; s < 4; s++) begin
         wait_grant(w, at);
         chk("R4 real-time order", w, (s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 3 : 0);
         finish_grant(w, len, d);
      end
      req = '0;

      // R5: round robin among best-effort cores
      setcfg(4'b0000, 0, 1, 0);
      req = 4'b1111;
      for (int s = 0; s < 5; s++) begin
         wait_grant(w, at);
         chk("R5 best-effort order", w, s % N);
         finish_grant(w, len, d);
      end
      req = '0;

      // R5: best-effort pointer not moved by a real-time grant
      setcfg(4'b0011, 0, 1, 0);
      req = 4'b0100;
      wait_grant(w, at); finish_grant(w, len, d); req = '0;
      @(negedge clk); req = 4'b0010;
      wait_grant(w, at); finish_grant(w, len, d); req = '0;
      @(negedge clk); req = 4'b1100;
      wait_grant(w, at);
      chk("R5 independent pointer", w, 3);
      req = '0;

      // R10: analysis mode, single core, bound sweep
      for (int n = 1; n <= 2; n++) begin
         for (int lb = 1; lb <= 3; lb++) begin
            for (int lk = 0; lk <= 4; lk += 2) begin
               setcfg(4'((1 << n) - 1), 2, lb, lk);
               b = bnd(n, lb, lk);
               c = cyc; req[0] = 1'b1;
               wait_grant(w, at);
               chk("R10 analysis delay", at - c, 1 + b);
               finish_grant(w, len, d);
               req[0] = 1'b0;
            end
         end
      end

      // R11: bank latency change during a grant (B 5 -> 9)
      setcfg(4'b0001, 1, 6, 0);
      req[0] = 1'b1;
      wait_grant(w, at);
      lat_bank = 4'd10;
      finish_grant(w, len, d);
      wait_grant(w, at);
      chk("R11 old bound kept", at - d, 2 + 5);
      finish_grant(w, len, d);
      wait_grant(w, at);
      chk("R11 new bound after idle", at - d, 2 + 9);
      req = '0;

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule